// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Bus Handover

This block moves a block of words between one peripheral and memory without the processor. The processor programs it through a small register port while it owns the bus. It writes a start address, a word count and a control word. Once the control word has the enable bit set, a request from the peripheral makes the engine ask the processor for the bus. Once the processor hands the bus over, the engine drives the memory address and one strobe per word, and it acknowledges the peripheral in the same cycle so the peripheral sources or sinks the data word.

Two pacing styles are available. In burst mode the whole block moves back to back during one bus tenure. In cycle-stealing mode the engine gives the bus back after every word and asks for it again. When the count runs out, the engine releases the bus, clears its enable bit and raises an interrupt. The interrupt stays high until the processor writes the control word.

Top module: `dma_channel`

## Requirements
- R1: Registers are written only on a clock edge where cpu_sel=1, cpu_wr=1 and bus_grant=0. cpu_rs selects the register: 0 is the start address, 1 is the word count and 2 is the control word. cpu_rdata returns the selected register while cpu_sel=1 and bus_grant=0, and returns 0 otherwise.
- R2: Control bit 0 sets the direction. A value of 0 moves memory to device and each word pulses mem_rd. A value of 1 moves device to memory and each word pulses mem_wr. The two strobes are never high together.
- R3: bus_req rises one cycle after dev_req is sampled high while the channel is armed. Armed means control bit 2 is set and the count is nonzero. With bit 2 clear or a count of zero, bus_req stays low.
- R4: A strobe, dev_ack and a nonzero mem_addr appear only in the cycle after an edge where bus_grant, dev_req and bus_req were all high. Outside a strobe cycle, mem_addr is 0.
- R5: Each word uses exactly one clock cycle with its strobe high. dev_ack is high in exactly that cycle.
- R6: mem_addr carries the address register value from before the step. After each word the address register increments, wrapping at its width, and the count decrements.
- R7: On the edge that launches the word that takes the count to zero, bus_req falls, irq rises and control bit 2 clears.
- R8: Control bit 1 = 0 selects burst mode. While grant and dev_req stay high, words follow one per cycle with no idle cycle and no release of bus_req.
- R9: Control bit 1 = 1 selects cycle stealing. bus_req falls on the edge that launches each word, and it is not raised again until bus_grant has been seen low.
- R10: irq stays high until a control-word write is accepted, and that write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_sel | input | 1 | Register port select from the processor |
| cpu_wr | input | 1 | Register write enable |
| cpu_rs | input | 2 | Register select: 0 address, 1 count, 2 control |
| cpu_wdata | input | DW | Register write data |
| cpu_rdata | output | DW | Register read data |
| dev_req | input | 1 | Transfer request from the peripheral |
| dev_ack | output | 1 | Per-word acknowledge to the peripheral |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus grant from the processor |
| mem_addr | output | AW | Memory address, valid during a strobe |
| mem_rd | output | 1 | Memory read strobe (memory to device) |
| mem_wr | output | 1 | Memory write strobe (device to memory) |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong count or address register shows at the ports on the very next strobe. mem_addr then carries an unexpected value, or the number of strobes before irq differs from the programmed count, which becomes visible as soon as the block ends. A sequencer stuck in the wrong state shows within one cycle as bus_req that never falls after a cycle-stealing word, as an idle gap inside a burst, or as a strobe without grant. A control register that failed to self-clear or to clear the interrupt is caught by reading it back, and by irq, right after the block ends.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_CTRL  = 2'd2
  } reg_sel_e;

  // control word layout: bit 2 enable, bit 1 steal mode, bit 0 device-to-memory
  typedef struct packed {
    logic en;
    logic steal;
    logic dev_to_mem;
  } ctrl_t;

  localparam int CTRL_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_OWN     = 2'd1,
    ST_RELEASE = 2'd2
  } dma_state_e;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_ok,
  input  logic [1:0]    rs,
  input  logic [DW-1:0] wdata,
  input  logic          rd_ok,
  input  logic          word_go,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] count_q,
  output ctrl_t         ctrl_q,
  output logic          irq_q,
  output logic          last_word,
  output logic          armed,
  output logic [DW-1:0] rdata
);

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  assign last_word = (count_q == CW'(1));
  assign armed     = ctrl_q.en && (count_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      count_q <= '0;
      ctrl_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (word_go) begin
        addr_q  <= step_addr(addr_q);
        count_q <= step_count(count_q);
        if (last_word) begin
          ctrl_q.en <= 1'b0;
          irq_q     <= 1'b1;
        end
      end
      if (wr_ok) begin
        unique case (rs)
          SEL_ADDR:  addr_q  <= wdata[AW-1:0];
          SEL_COUNT: count_q <= wdata[CW-1:0];
          SEL_CTRL: begin
            ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
            irq_q  <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      unique case (rs)
        SEL_ADDR:  rdata = DW'(addr_q);
        SEL_COUNT: rdata = DW'(count_q);
        SEL_CTRL:  rdata = DW'(ctrl_q);
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_fsm.sv
module dma_fsm
  import dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic steal,
  input  logic last_word,
  input  logic dev_req,
  input  logic bus_grant,
  output logic word_go,
  output logic bus_req
);

  dma_state_e state_q, state_d;

  assign word_go = (state_q == ST_OWN) && bus_grant && dev_req && armed;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (armed && dev_req) state_d = ST_OWN;
      ST_OWN: begin
        if (!armed)           state_d = ST_IDLE;
        else if (word_go) begin
          if (last_word)      state_d = ST_IDLE;
          else if (steal)     state_d = ST_RELEASE;
        end
      end
      ST_RELEASE: if (!bus_grant) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bus_req <= 1'b0;
    end else begin
      state_q <= state_d;
      bus_req <= (state_d == ST_OWN);
    end
  end

endmodule

// File: rtl/dma_strobe.sv
module dma_strobe #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_go,
  input  logic          dev_to_mem,
  input  logic [AW-1:0] addr_q,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          dev_ack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_rd   <= 1'b0;
      mem_wr   <= 1'b0;
      dev_ack  <= 1'b0;
    end else begin
      mem_addr <= word_go ? addr_q : '0;
      mem_rd   <= word_go && !dev_to_mem;
      mem_wr   <= word_go && dev_to_mem;
      dev_ack  <= word_go;
    end
  end

endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_rs,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dev_req,
  output logic          dev_ack,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic          irq
);

  // named internal events, visible to the bound checker
  logic          rd_ok, wr_ok;
  logic          word_go, last_word, armed;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] count_q;
  ctrl_t         ctrl_q;
  logic          steal;

  assign rd_ok = cpu_sel && !bus_grant;
  assign wr_ok = rd_ok && cpu_wr;
  assign steal = ctrl_q.steal;

  dma_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_ok     (wr_ok),
    .rs        (cpu_rs),
    .wdata     (cpu_wdata),
    .rd_ok     (rd_ok),
    .word_go   (word_go),
    .addr_q    (addr_q),
    .count_q   (count_q),
    .ctrl_q    (ctrl_q),
    .irq_q     (irq),
    .last_word (last_word),
    .armed     (armed),
    .rdata     (cpu_rdata)
  );

  dma_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .armed     (armed),
    .steal     (steal),
    .last_word (last_word),
    .dev_req   (dev_req),
    .bus_grant (bus_grant),
    .word_go   (word_go),
    .bus_req   (bus_req)
  );

  dma_strobe #(.AW(AW)) u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_go    (word_go),
    .dev_to_mem (ctrl_q.dev_to_mem),
    .addr_q     (addr_q),
    .mem_addr   (mem_addr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .dev_ack    (dev_ack)
  );

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_sel,
  input logic          cpu_wr,
  input logic [1:0]    cpu_rs,
  input logic          bus_grant,
  input logic          bus_req,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic [AW-1:0] mem_addr,
  input logic          irq,
  input logic          word_go,
  input logic          last_word,
  input logic          steal,
  input logic [AW-1:0] addr_q,
  input logic [CW-1:0] count_q
);

  // R1: a write attempted under grant leaves the address register alone
  a_r1_locked_under_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && cpu_sel && cpu_wr && cpu_rs == 2'd0 && !word_go) |=> $stable(addr_q));

  // R2
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd, mem_wr}));

  // R3
  a_r3_req_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> $past(dev_req));

  // R4
  a_r4_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> $past(bus_grant));

  // R5 and R6
  a_r5_ack_with_addr: assert property (@(posedge clk) disable iff (!rst_n)
    word_go |=> (dev_ack && mem_addr == $past(addr_q)));

  // R6
  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    word_go |=> (count_q == $past(count_q) - CW'(1)));

  // R7
  a_r7_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (word_go && last_word) |=> (irq && !bus_req));

  // R9
  a_r9_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
    (word_go && steal) |=> !bus_req);

  // R10
  a_r10_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cpu_sel && cpu_wr && !bus_grant && cpu_rs == 2'd2)) |=> irq);

endmodule

bind dma_channel dma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_sel   (cpu_sel),
  .cpu_wr    (cpu_wr),
  .cpu_rs    (cpu_rs),
  .bus_grant (bus_grant),
  .bus_req   (bus_req),
  .dev_req   (dev_req),
  .dev_ack   (dev_ack),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_addr  (mem_addr),
  .irq       (irq),
  .word_go   (word_go),
  .last_word (last_word),
  .steal     (steal),
  .addr_q    (addr_q),
  .count_q   (count_q)
);

// File: tb/dma_channel_bench.sv
`timescale 1ns/1ps
module dma_channel_bench;

  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [1:0]    cpu_rs = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          dev_req = 1'b0, dev_ack;
  logic          bus_req, bus_grant = 1'b0;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, irq;

  always #2.5 clk = ~clk;

  dma_channel #(.AW(AW), .CW(CW), .DW(DW)) u_dma_channel (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // processor model: grants one half-cycle after it sees a request
  bit force_gnt = 0;
  always @(negedge clk) bus_grant <= force_gnt | bus_req;

  // port monitor
  bit            mon_on = 0, exp_dir = 0, exp_steal = 0;
  logic [AW-1:0] exp_addr;
  int            n_exp = 0, words = 0, gaps = 0, glow = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_rd || mem_wr) begin
        chk(mem_addr == exp_addr, "R6 word address", mem_addr, exp_addr);
        chk(mem_wr == exp_dir && mem_rd == !exp_dir, "R2 strobe type", {mem_wr, mem_rd}, {exp_dir, !exp_dir});
        chk(dev_ack, "R5 ack with strobe", dev_ack, 1);
        chk(bus_grant, "R4 strobe under grant", bus_grant, 1);
        if (exp_steal) chk(!bus_req, "R9 request dropped per word", bus_req, 0);
        exp_addr = exp_addr + AW'(1);
        words++;
      end else begin
        if (mem_addr != '0 || dev_ack) chk(0, "R4 idle outputs", {dev_ack, mem_addr}, 0);
        if (words > 0 && words < n_exp) begin
          gaps++;
          if (!bus_grant) glow++;
        end
      end
    end
  end

  task automatic cpu_write(input logic [1:0] rs, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_wr = 1; cpu_rs = rs; cpu_wdata = d;
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic cpu_read(input logic [1:0] rs, output logic [DW-1:0] d);
    @(negedge clk);
    cpu_sel = 1; cpu_rs = rs;
    #1 d = cpu_rdata;
    cpu_sel = 0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    chk({bus_req, mem_rd, mem_wr, dev_ack, irq} == 0, "R4 reset outputs",
        {bus_req, mem_rd, mem_wr, dev_ack, irq}, 0);
    cpu_read(2'd1, v);
    chk(v == 0, "R1 reset count", v, 0);
  endtask

  task automatic t_block(input bit dir, input bit steal_m, input logic [AW-1:0] start, input int n);
    logic [DW-1:0] v;
    bit seen = 0;
    cpu_write(2'd0, start);
    cpu_write(2'd1, DW'(n));
    cpu_write(2'd2, DW'({1'b1, steal_m, dir}));
    exp_addr = start; exp_dir = dir; exp_steal = steal_m;
    n_exp = n; words = 0; gaps = 0; glow = 0; mon_on = 1;
    @(negedge clk); dev_req = 1;
    @(negedge clk); #1;
    chk(bus_req, "R3 request latency", bus_req, 1);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); #1;
      if (irq) begin seen = 1; break; end
    end
    chk(seen, "R7 interrupt raised", seen, 1);
    chk(!bus_req, "R7 request dropped at end", bus_req, 0);
    dev_req = 0;
    repeat (3) @(negedge clk);
    #1 mon_on = 0;
    chk(words == n, "R6 word total", words, n);
    if (steal_m) chk(glow >= n - 1, "R9 bus returned between words", glow, n - 1);
    else         chk(gaps == 0, "R8 back-to-back burst", gaps, 0);
    cpu_read(2'd0, v);
    chk(v == DW'(start + AW'(n)), "R6 final address", v, start + AW'(n));
    cpu_read(2'd1, v);
    chk(v == 0, "R6 final count", v, 0);
    cpu_read(2'd2, v);
    chk(v == DW'({1'b0, steal_m, dir}), "R7 enable self-clear", v, {1'b0, steal_m, dir});
    chk(irq, "R10 irq held", irq, 1);
    cpu_write(2'd2, '0);
    #1 chk(!irq, "R10 irq cleared by control write", irq, 0);
  endtask

  task automatic t_not_armed(input logic [DW-1:0] cnt, input logic [DW-1:0] ctl, input string tag);
    bit rose = 0;
    cpu_write(2'd1, cnt);
    cpu_write(2'd2, ctl);
    @(negedge clk); dev_req = 1;
    repeat (8) begin @(negedge clk); #1 if (bus_req) rose = 1; end
    dev_req = 0;
    chk(!rose, tag, rose, 0);
    cpu_write(2'd2, '0);
  endtask

  task automatic t_grant_lock();
    logic [DW-1:0] v;
    cpu_write(2'd0, 16'h00A5);
    force_gnt = 1;
    repeat (2) @(negedge clk);
    cpu_write(2'd0, 16'h1234);
    cpu_read(2'd0, v);
    chk(v == 0, "R1 readback blank under grant", v, 0);
    force_gnt = 0;
    repeat (2) @(negedge clk);
    cpu_read(2'd0, v);
    chk(v == 16'h00A5, "R1 write ignored under grant", v, 16'h00A5);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_block(1'b0, 1'b0, 16'h0100, 4);
    t_block(1'b1, 1'b0, 16'h2000, 7);
    t_block(1'b0, 1'b1, 16'h0040, 3);
    t_block(1'b1, 1'b1, 16'hFFFE, 4);
    t_block(1'b1, 1'b0, 16'hFFFF, 1);
    t_not_armed(16'd5, 16'h0000, "R3 no request when disabled");
    t_not_armed(16'd0, 16'h0004, "R3 no request with zero count");
    t_grant_lock();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule